// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Bank

This block keeps the interrupt bookkeeping for one DMA channel. Eight event lines from the datapath set sticky flag bits, and software clears a flag by writing a one to it. A hidden mask gates each flag onto a single level interrupt line. Software never writes the mask directly. A write-only "unmask" port clears mask bits, a write-only "mask" port sets them, and a read-only view shows the current mask.

A 3-bit counter tracks completed transfers that software has not yet acknowledged. Each completion pulse counts up. Each software clear of a pending completion flag counts down. The counter sits in a channel word next to read-only busy, outstanding-request and fifo-level fields that the datapath supplies.

The register port takes full 32-bit accesses, and read data is registered. Any access to an offset outside the map raises the invalid-access flag.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset the flag word (offset 0x00) reads 0, the mask view (offset 0x0C) reads 0xFF, the completion count is 0 and `irq_o` is low.
- R2: A high bit on `evt_i` sets the matching flag bit at the next clock edge. In the flag word, bit 7 is overflow, 6 invalid access, 5 threshold, 4 memory timeout, 3 stream timeout, 2 bus error, 1 done and 0 memory done. Writing 1 to a flag bit at offset 0x00 clears it, and writing 0 leaves it unchanged.
- R3: Writing 1 to a bit at offset 0x04 clears the matching mask bit. Offset 0x04 reads as 0.
- R4: Writing 1 to a bit at offset 0x08 sets the matching mask bit. Offset 0x08 reads as 0.
- R5: The mask view at offset 0x0C is read-only, and a write to it changes nothing.
- R6: `irq_o` is high exactly when some flag bit is set and its mask bit is clear. It follows every flag, unmask or mask change in the same cycle that the change lands.
- R7: Each done event (evt_i bit 1) adds one to the completion count, which reads in bits 15:13 of offset 0x10 and wraps modulo 8.
- R8: A write to offset 0x00 that clears a set done flag subtracts one from the count. The same write with the done flag already clear leaves the count unchanged.
- R9: A write to offset 0x10 with any 1 in bits 15:13 zeroes the count. The other bits of that write are ignored.
- R10: Offset 0x10 returns `busy_i` in bit 0, `outs_i` in bits 4:1 and `lvl_i` in bits 12:5.
- R11: If an event and a clear hit the same bit in one cycle, the event wins and the bit stays set. For the done flag the count then rises by one. A done event during a count-zeroing write leaves the count at 1.
- R12: A read or write to any offset other than 0x00, 0x04, 0x08, 0x0C and 0x10 sets flag bit 6. A read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| evt_i | input | NUM_SRC | Event pulses, one per flag bit |
| busy_i | input | 1 | Channel busy, shown in the channel word |
| outs_i | input | OUTS_W | Outstanding request count, shown in the channel word |
| lvl_i | input | LVL_W | Fifo level, shown in the channel word |
| irq_o | output | 1 | Level interrupt |

## Verification
Two things can land on the same flag in one cycle: a datapath event and a software write-one clear. The same is true of a completion pulse and a count-zeroing write. The bench drives an event pulse and the clearing register write in the same clock. It then reads the flag word and the channel word. The bit must still be set, and the count must show the event taken and the clear dropped: up by one, or exactly 1 after a zeroing write.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned OFS_FLAGS   = 32'h00;
  localparam int unsigned OFS_UNMASK  = 32'h04;
  localparam int unsigned OFS_MASKSET = 32'h08;
  localparam int unsigned OFS_MASKVW  = 32'h0C;
  localparam int unsigned OFS_CHAN    = 32'h10;

  localparam int unsigned BIT_INVALID = 6;
  localparam int unsigned BIT_DONE    = 1;

  typedef struct packed {
    logic flags;
    logic unmask;
    logic maskset;
    logic maskvw;
    logic chan;
  } reg_sel_t;
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic              bad
);
  always_comb begin
    sel.flags   = (addr == ADDR_W'(OFS_FLAGS));
    sel.unmask  = (addr == ADDR_W'(OFS_UNMASK));
    sel.maskset = (addr == ADDR_W'(OFS_MASKSET));
    sel.maskvw  = (addr == ADDR_W'(OFS_MASKVW));
    sel.chan    = (addr == ADDR_W'(OFS_CHAN));
    bad         = acc && (sel == '0);
  end
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               wr_clr,
  input  logic               wr_unmask,
  input  logic               wr_maskset,
  input  logic [NUM_SRC-1:0] wbits,
  output logic [NUM_SRC-1:0] flag_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] flag_nx;
  logic [NUM_SRC-1:0] mask_nx;

  // Per-source next state: the event has priority over a write-one clear.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_comb begin
      flag_nx[i] = evt[i] | (flag_q[i] & ~(wr_clr & wbits[i]));
      mask_nx[i] = (mask_q[i] | (wr_maskset & wbits[i])) & ~(wr_unmask & wbits[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      mask_q <= mask_nx;
      irq_q  <= |(flag_nx & ~mask_nx);
    end
  end
endmodule

// File: rtl/dma_irq_donecnt.sv
module dma_irq_donecnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic             zero,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (zero) begin
      cnt_q <= inc ? CNT_W'(1) : '0;
    end else if (inc && !dec) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (dec && !inc) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 3,
  parameter int OUTS_W  = 4,
  parameter int LVL_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic              busy_i,
  input  logic [OUTS_W-1:0] outs_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic              irq_o
);
  localparam int LVL_LSB = 1 + OUTS_W;
  localparam int CNT_LSB = LVL_LSB + LVL_W;

  reg_sel_t           sel;
  logic               bad_acc;
  logic [NUM_SRC-1:0] evt_all;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               cnt_dec;
  logic               cnt_zero;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc  (bus_wr | bus_rd),
    .addr (bus_addr),
    .sel  (sel),
    .bad  (bad_acc)
  );

  always_comb begin
    evt_all              = evt_i;
    evt_all[BIT_INVALID] = evt_i[BIT_INVALID] | bad_acc;
  end

  dma_irq_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt_all),
    .wr_clr     (bus_wr & sel.flags),
    .wr_unmask  (bus_wr & sel.unmask),
    .wr_maskset (bus_wr & sel.maskset),
    .wbits      (bus_wdata[NUM_SRC-1:0]),
    .flag_q     (flag_q),
    .mask_q     (mask_q),
    .irq_q      (irq_o)
  );

  // A clear only counts when it really removes a pending done flag.
  assign cnt_dec  = bus_wr & sel.flags & bus_wdata[BIT_DONE]
                  & flag_q[BIT_DONE] & ~evt_all[BIT_DONE];
  assign cnt_zero = bus_wr & sel.chan & (|bus_wdata[CNT_LSB +: CNT_W]);

  dma_irq_donecnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (evt_all[BIT_DONE]),
    .dec   (cnt_dec),
    .zero  (cnt_zero),
    .cnt_q (cnt_q)
  );

  always_comb begin
    rd_mux = '0;
    if (sel.flags) begin
      rd_mux[NUM_SRC-1:0] = flag_q;
    end else if (sel.maskvw) begin
      rd_mux[NUM_SRC-1:0] = mask_q;
    end else if (sel.chan) begin
      rd_mux[0]                   = busy_i;
      rd_mux[1 +: OUTS_W]         = outs_i;
      rd_mux[LVL_LSB +: LVL_W]    = lvl_i;
      rd_mux[CNT_LSB +: CNT_W]    = cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/dma_irq_bank_chk.sv
module dma_irq_bank_chk #(
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 8,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               wr,
  input logic               rd,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_SRC-1:0] evt,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] mask,
  input logic [CNT_W-1:0]   cnt,
  input logic               irq
);
  logic known_ofs;
  assign known_ofs = (addr == ADDR_W'(8'h00)) || (addr == ADDR_W'(8'h04)) ||
                     (addr == ADDR_W'(8'h08)) || (addr == ADDR_W'(8'h0C)) ||
                     (addr == ADDR_W'(8'h10));

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (mask == '1 && flags == '0 && cnt == '0 && !irq)); // R1

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags & $past(evt)) == $past(evt))); // R11

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & ~mask)); // R6

  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!evt[1] && !(wr && (addr == ADDR_W'(8'h00) || addr == ADDR_W'(8'h10))))
    |=> $stable(cnt)); // R7

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr && (addr == ADDR_W'(8'h04) || addr == ADDR_W'(8'h08)))
    |=> $stable(mask)); // R5

  AST_BAD_ACCESS: assert property (@(posedge clk) disable iff (rst)
    ((wr || rd) && !known_ofs) |=> flags[6]); // R12
endmodule

bind dma_irq_bank dma_irq_bank_chk #(
  .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .CNT_W(CNT_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr    (bus_wr),
  .rd    (bus_rd),
  .addr  (bus_addr),
  .evt   (evt_i),
  .flags (flag_q),
  .mask  (mask_q),
  .cnt   (cnt_q),
  .irq   (irq_o)
);

// File: tb/dma_irq_bank_test.sv
module dma_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_i = '0;
  logic        busy_i = 1'b0;
  logic [3:0]  outs_i = '0;
  logic [7:0]  lvl_i = '0;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_irq_bank uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt_i), .busy_i(busy_i), .outs_i(outs_i), .lvl_i(lvl_i),
    .irq_o(irq_o)
  );

  // {req[8], op[4], addr[8], data[32], exp[32]}; op 0 write, 1 read, 2 event, 3 irq
  localparam logic [83:0] VEC [19] = '{
    {8'd1, 4'd1, 8'h0C, 32'h0,  32'hFF},   // R1
    {8'd1, 4'd1, 8'h00, 32'h0,  32'h00},   // R1
    {8'd2, 4'd2, 8'h00, 32'h21, 32'h0},    // R2
    {8'd2, 4'd1, 8'h00, 32'h0,  32'h21},   // R2
    {8'd6, 4'd3, 8'h00, 32'h0,  32'h0},    // R6
    {8'd3, 4'd0, 8'h04, 32'h01, 32'h0},    // R3
    {8'd3, 4'd1, 8'h0C, 32'h0,  32'hFE},   // R3
    {8'd6, 4'd3, 8'h00, 32'h0,  32'h1},    // R6
    {8'd3, 4'd1, 8'h04, 32'h0,  32'h0},    // R3
    {8'd2, 4'd0, 8'h00, 32'h20, 32'h0},    // R2
    {8'd2, 4'd1, 8'h00, 32'h0,  32'h01},   // R2
    {8'd4, 4'd0, 8'h08, 32'h01, 32'h0},    // R4
    {8'd4, 4'd1, 8'h0C, 32'h0,  32'hFF},   // R4
    {8'd6, 4'd3, 8'h00, 32'h0,  32'h0},    // R6
    {8'd4, 4'd1, 8'h08, 32'h0,  32'h0},    // R4
    {8'd5, 4'd0, 8'h0C, 32'h0,  32'h0},    // R5
    {8'd5, 4'd1, 8'h0C, 32'h0,  32'hFF},   // R5
    {8'd2, 4'd0, 8'h00, 32'h01, 32'h0},    // R2
    {8'd2, 4'd1, 8'h00, 32'h0,  32'h00}    // R2
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // One clock of stimulus, starting and ending on a falling edge.
  task automatic cyc(logic wr, logic rd, logic [7:0] a, logic [31:0] d, logic [7:0] e);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_i = e;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; evt_i = '0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    cyc(1'b0, 1'b1, a, 32'h0, 8'h0);
    check(tag, bus_rdata, exp);
  endtask

  function automatic logic [31:0] chan_exp(logic [2:0] c);
    return {16'h0, c, 8'hA5, 4'd5, 1'b1};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {31'h0, irq_o}, 32'h0);

    for (int k = 0; k < 19; k++) begin
      automatic logic [7:0]  req = VEC[k][83:76];
      automatic logic [3:0]  op  = VEC[k][75:72];
      automatic logic [7:0]  a   = VEC[k][71:64];
      automatic logic [31:0] d   = VEC[k][63:32];
      automatic logic [31:0] x   = VEC[k][31:0];
      case (op)
        4'd0: cyc(1'b1, 1'b0, a, d, 8'h0);
        4'd1: rd_chk($sformatf("R%0d vec%0d", req, k), a, x);
        4'd2: cyc(1'b0, 1'b0, 8'h0, 32'h0, d[7:0]);
        default: check($sformatf("R%0d vec%0d irq", req, k), {31'h0, irq_o}, x);
      endcase
    end

    // R10: read-only datapath fields
    busy_i = 1'b1; outs_i = 4'd5; lvl_i = 8'hA5;
    rd_chk("R10 chan word", 8'h10, chan_exp(3'd0));

    // R7: three completions
    repeat (3) cyc(1'b0, 1'b0, 8'h0, 32'h0, 8'h02);
    rd_chk("R7 count 3", 8'h10, chan_exp(3'd3));

    // R8: clearing a set done flag decrements; clearing it again does not
    cyc(1'b1, 1'b0, 8'h00, 32'h02, 8'h0);
    rd_chk("R8 done flag cleared", 8'h00, 32'h0);
    rd_chk("R8 count 2", 8'h10, chan_exp(3'd2));
    cyc(1'b1, 1'b0, 8'h00, 32'h02, 8'h0);
    rd_chk("R8 count kept", 8'h10, chan_exp(3'd2));

    // R7: wrap modulo 8
    repeat (6) cyc(1'b0, 1'b0, 8'h0, 32'h0, 8'h02);
    rd_chk("R7 wrap to 0", 8'h10, chan_exp(3'd0));
    cyc(1'b0, 1'b0, 8'h0, 32'h0, 8'h02);
    rd_chk("R7 count 1", 8'h10, chan_exp(3'd1));

    // R9: only bits 15:13 zero the count
    cyc(1'b1, 1'b0, 8'h10, 32'hFFFF_1FFF, 8'h0);
    rd_chk("R9 other bits ignored", 8'h10, chan_exp(3'd1));
    cyc(1'b1, 1'b0, 8'h10, 32'h0000_4000, 8'h0);
    rd_chk("R9 count zeroed", 8'h10, chan_exp(3'd0));

    // R11: done event together with a done clear (flag is set)
    cyc(1'b1, 1'b0, 8'h00, 32'h02, 8'h02);
    rd_chk("R11 done flag kept", 8'h00, 32'h02);
    rd_chk("R11 count up", 8'h10, chan_exp(3'd1));
    cyc(1'b1, 1'b0, 8'h10, 32'h2000, 8'h02);
    rd_chk("R11 zero with event", 8'h10, chan_exp(3'd1));
    cyc(1'b0, 1'b0, 8'h0, 32'h0, 8'h08);
    cyc(1'b1, 1'b0, 8'h00, 32'h08, 8'h08);
    rd_chk("R11 timeout kept", 8'h00, 32'h0A);
    cyc(1'b1, 1'b0, 8'h00, 32'h08, 8'h0);
    rd_chk("R2 timeout cleared", 8'h00, 32'h02);

    // R12: unmapped offsets
    rd_chk("R12 bad read data", 8'h14, 32'h0);
    rd_chk("R12 invalid flag", 8'h00, 32'h42);
    cyc(1'b1, 1'b0, 8'h04, 32'h40, 8'h0);
    check("R6 irq invalid", {31'h0, irq_o}, 32'h1);
    cyc(1'b1, 1'b0, 8'h00, 32'h40, 8'h0);
    check("R6 irq dropped", {31'h0, irq_o}, 32'h0);
    cyc(1'b1, 1'b0, 8'h3C, 32'h0, 8'h0);
    check("R12 bad write irq", {31'h0, irq_o}, 32'h1);

    // R1: reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {31'h0, irq_o}, 32'h0);
    rd_chk("R1 mask after reset", 8'h0C, 32'hFF);
    rd_chk("R1 count after reset", 8'h10, chan_exp(3'd0));

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule